// File: doc/BRIEF.md
# Two-Channel Burst-Capable Pulse Generator

This block drives two independent pulse outputs. Each output repeats a period made of a high stretch followed by a low stretch. Both stretches are counted in timebase units. One unit is 100 microseconds, which is `TICK_DIV` system clocks. A channel can run without end, or it can stop by itself after a programmed number of full periods.

All settings arrive as command/parameter pairs from an upstream mailbox decoder. There are three per-channel settings: high length, low length and burst count. A shared enable mask starts and stops the channels. Any setting can be read back by presenting its command code on a separate read select. The read returns one cycle later.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset, both outputs are low, the enable mask reads 0, every stored high and low length reads 1, and every burst count reads 0.
- R2: A command with code 0x10+2c stores its 16-bit parameter as the high length of channel c. A command with code 0x11+2c stores it as the low length. Reading back with the same code returns the stored value.
- R3: A command with code 0x14+c stores its parameter as the burst count of channel c. Reading back with that code returns it.
- R4: Command 0x1F writes the enable mask from parameter bits [1:0], where bit c enables channel c. Read select 0x1F returns the mask in bits [1:0] and zeros above.
- R5: When a channel's enable bit rises, its output goes high on the second clock edge after the command is sampled. The high stretch then lasts exactly high×`TICK_DIV` clocks and the low stretch exactly low×`TICK_DIV` clocks.
- R6: With a burst count of 0, a channel repeats its period until it is disabled.
- R7: With a burst count of N>0, a channel produces N full high stretches and N low stretches. It then stays low, and its enable bit reads 0.
- R8: Clearing a channel's enable bit drives its output low on the second clock edge after the command is sampled, even in the middle of a high stretch. The output stays low afterwards.
- R9: New high and low lengths written while a channel runs do not change the period in progress. They take effect from the next period on.
- R10: The two channels run concurrently, and neither one's settings, burst end or enable affects the other.
- R11: Commands with codes outside the set in R2 to R4 change no stored value and no output.
- R12: A read select that is not one of the codes in R2 to R4 returns 0, and every read request is answered by `rd_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| cmd_param | input | VAL_W | Command parameter |
| rd_req | input | 1 | Readback request |
| rd_sel | input | 8 | Code of the setting to read back |
| rd_valid | output | 1 | Readback data valid, one cycle after rd_req |
| rd_data | output | VAL_W | Readback data |
| pwm_out | output | NUM_CH | Registered pulse outputs, bit c is channel c |

## Verification
Channel 0 first runs alone without end. Its lengths are rewritten during the first high stretch, so the measured periods show whether a new value is applied at once or at the period boundary. Both channels then run together: one runs without end while the other runs a three-period burst. This separates a correct burst end from an off-by-one count or a stop that spills into the other channel. A disable is issued right after a rising edge, which shows whether the output is forced low at once or only when the period ends. Readback and unused codes are checked at the ports after each change.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

  localparam int CMD_HI_BASE    = 'h10;
  localparam int CMD_LO_BASE    = 'h11;
  localparam int CMD_BURST_BASE = 'h14;
  localparam int CMD_ENABLE     = 'h1F;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  function automatic logic [7:0] hi_code(input int c);
    return 8'(CMD_HI_BASE + 2 * c);
  endfunction

  function automatic logic [7:0] lo_code(input int c);
    return 8'(CMD_LO_BASE + 2 * c);
  endfunction

  function automatic logic [7:0] burst_code(input int c);
    return 8'(CMD_BURST_BASE + c);
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TICK_DIV = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int SW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [SW-1:0] LAST = SW'(TICK_DIV - 1);

  logic [SW-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      sub <= '0;
    end else if (sub == LAST) begin
      sub <= '0;
    end else begin
      sub <= sub + SW'(1);
    end
  end

  assign tick = run && (sub == LAST);

  // R5: the sub-unit counter is cleared on every restart, so durations are exact
  p_restart_clears_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (sub == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_burst_pkg::*;
#(
  parameter int VAL_W    = 16,
  parameter int TICK_DIV = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [VAL_W-1:0] hi_val,
  input  logic [VAL_W-1:0] lo_val,
  input  logic [VAL_W-1:0] burst_val,
  output logic             pwm_o,
  output logic             done_o
);
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  phase_e           phase;
  logic             en_q;
  logic [VAL_W-1:0] cnt;
  logic [VAL_W-1:0] lo_l;
  logic [VAL_W-1:0] burst_l;
  logic [VAL_W-1:0] periods;
  logic             start;
  logic             run;
  logic             tick;
  logic             last;
  logic             burst_end;

  assign start     = en && !en_q;
  assign run       = en && (phase != PH_IDLE);
  assign last      = (cnt <= ONE);
  assign burst_end = (burst_l != '0) && (periods == burst_l - ONE);

  pwm_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (run),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      en_q    <= 1'b0;
      cnt     <= '0;
      lo_l    <= '0;
      burst_l <= '0;
      periods <= '0;
      pwm_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      en_q   <= en;
      done_o <= 1'b0;
      if (!en) begin
        phase <= PH_IDLE;
        pwm_o <= 1'b0;
      end else if (start) begin
        phase   <= PH_HIGH;
        pwm_o   <= 1'b1;
        cnt     <= hi_val;
        lo_l    <= lo_val;
        burst_l <= burst_val;
        periods <= '0;
      end else if (tick) begin
        unique case (phase)
          PH_HIGH: begin
            if (last) begin
              phase <= PH_LOW;
              pwm_o <= 1'b0;
              cnt   <= lo_l;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          PH_LOW: begin
            if (!last) begin
              cnt <= cnt - ONE;
            end else if (burst_end) begin
              phase  <= PH_IDLE;
              pwm_o  <= 1'b0;
              done_o <= 1'b1;
            end else begin
              phase   <= PH_HIGH;
              pwm_o   <= 1'b1;
              cnt     <= hi_val;
              lo_l    <= lo_val;
              periods <= periods + ONE;
            end
          end
          default: pwm_o <= 1'b0;
        endcase
      end
    end
  end

  p_start_high_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> pwm_o);

  p_disable_low_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o);

  p_done_low_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!pwm_o && phase == PH_IDLE));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_burst_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int VAL_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [7:0]                   cmd_code,
  input  logic [VAL_W-1:0]             cmd_param,
  input  logic                         rd_req,
  input  logic [7:0]                   rd_sel,
  input  logic [NUM_CH-1:0]            ch_done,
  output logic [NUM_CH-1:0][VAL_W-1:0] hi_val,
  output logic [NUM_CH-1:0][VAL_W-1:0] lo_val,
  output logic [NUM_CH-1:0][VAL_W-1:0] burst_val,
  output logic [NUM_CH-1:0]            en_mask,
  output logic                         rd_valid,
  output logic [VAL_W-1:0]             rd_data
);
  localparam logic [7:0] EN_CODE = 8'(CMD_ENABLE);

  logic [VAL_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        hi_val[c]    <= VAL_W'(1);
        lo_val[c]    <= VAL_W'(1);
        burst_val[c] <= '0;
      end
      en_mask <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cmd_valid && cmd_code == hi_code(c))    hi_val[c]    <= cmd_param;
        if (cmd_valid && cmd_code == lo_code(c))    lo_val[c]    <= cmd_param;
        if (cmd_valid && cmd_code == burst_code(c)) burst_val[c] <= cmd_param;
      end
      if (cmd_valid && cmd_code == EN_CODE) begin
        en_mask <= cmd_param[NUM_CH-1:0] & ~ch_done;
      end else begin
        en_mask <= en_mask & ~ch_done;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_sel == hi_code(c))    rd_next = hi_val[c];
      if (rd_sel == lo_code(c))    rd_next = lo_val[c];
      if (rd_sel == burst_code(c)) rd_next = burst_val[c];
    end
    if (rd_sel == EN_CODE) rd_next = {{(VAL_W-NUM_CH){1'b0}}, en_mask};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end

  p_rd_answer_r12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ch_done[g] |=> !en_mask[g]);
      p_hi_store_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == hi_code(g)) |=> (hi_val[g] == $past(cmd_param)));
    end
  endgenerate

endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen #(
  parameter int NUM_CH   = 2,
  parameter int VAL_W    = 16,
  parameter int TICK_DIV = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [VAL_W-1:0]  cmd_param,
  input  logic              rd_req,
  input  logic [7:0]        rd_sel,
  output logic              rd_valid,
  output logic [VAL_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][VAL_W-1:0] hi_val;
  logic [NUM_CH-1:0][VAL_W-1:0] lo_val;
  logic [NUM_CH-1:0][VAL_W-1:0] burst_val;
  logic [NUM_CH-1:0]            en_mask;
  logic [NUM_CH-1:0]            ch_done;

  pwm_cfg_regs #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_param (cmd_param),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel),
    .ch_done   (ch_done),
    .hi_val    (hi_val),
    .lo_val    (lo_val),
    .burst_val (burst_val),
    .en_mask   (en_mask),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_channel #(.VAL_W(VAL_W), .TICK_DIV(TICK_DIV)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .en        (en_mask[c]),
        .hi_val    (hi_val[c]),
        .lo_val    (lo_val[c]),
        .burst_val (burst_val[c]),
        .pwm_o     (pwm_out[c]),
        .done_o    (ch_done[c])
      );

      // R10: an idle, disabled channel never drives its output high
      p_chan_iso_r10: assert property (@(posedge clk) disable iff (rst)
        (!en_mask[c] && !pwm_out[c]) |=> !pwm_out[c]);
    end
  endgenerate

endmodule

// File: tb/sim_pwm_burst_gen.sv
module sim_pwm_burst_gen;
  localparam int NUM_CH = 2;
  localparam int VAL_W  = 16;
  localparam int D      = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [7:0]        cmd_code = '0;
  logic [VAL_W-1:0]  cmd_param = '0;
  logic              rd_req = 1'b0;
  logic [7:0]        rd_sel = '0;
  logic              rd_valid;
  logic [VAL_W-1:0]  rd_data;
  logic [NUM_CH-1:0] pwm_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    q0[$];
  int    q1[$];
  int    rdq[$];
  string rdtag[$];
  bit    in_run[NUM_CH];
  bit    prev[NUM_CH];
  int    runlen[NUM_CH];

  always #2.5 clk = ~clk;

  pwm_burst_gen #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .TICK_DIV(D)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] code, input int param);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_param = VAL_W'(param);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_expect(input logic [7:0] sel, input int exp, input string tag);
    rdq.push_back(exp);
    rdtag.push_back(tag);
    @(negedge clk);
    rd_req = 1'b1;
    rd_sel = sel;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // item encoding: length*2 + level
  task automatic expect_seg(input int ch, input int lvl, input int len);
    if (ch == 0) q0.push_back(len * 2 + lvl);
    else         q1.push_back(len * 2 + lvl);
  endtask

  task automatic compare_seg(input int ch, input int lvl, input int len);
    int e;
    if (ch == 0) begin
      if (q0.size() == 0) return;
      e = q0.pop_front();
    end else begin
      if (q1.size() == 0) return;
      e = q1.pop_front();
    end
    check(e == len * 2 + lvl, $sformatf("R5/R9 ch%0d segment lvl=%0d", ch, lvl),
          len, e / 2);
  endtask

  // monitor: readback and pulse segments
  always @(negedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        prev[c] = 1'b0;
        runlen[c] = 0;
      end
    end else begin
      if (rd_valid) begin
        if (rdq.size() == 0) begin
          check(0, "R12 unexpected rd_valid", 1, 0);
        end else begin
          int e;
          string t;
          e = rdq.pop_front();
          t = rdtag.pop_front();
          check(int'(rd_data) == e, t, int'(rd_data), e);
        end
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (pwm_out[c] == prev[c]) begin
          runlen[c]++;
        end else begin
          if (prev[c]) compare_seg(c, 1, runlen[c]);
          else if (in_run[c]) compare_seg(c, 0, runlen[c]);
          if (pwm_out[c]) in_run[c] = 1'b1;
          runlen[c] = 1;
          prev[c] = pwm_out[c];
        end
      end
    end
  end

  task automatic wait_q(input int ch);
    for (int i = 0; i < 5000; i++) begin
      if ((ch == 0 ? q0.size() : q1.size()) == 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_run[0] = 0;
    in_run[1] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(pwm_out == 2'b00, "R1 outputs low after reset", int'(pwm_out), 0);
    read_expect(8'h10, 1, "R1 hi0 reset");
    read_expect(8'h13, 1, "R1 lo1 reset");
    read_expect(8'h15, 0, "R1 burst1 reset");
    read_expect(8'h1F, 0, "R1 mask reset");

    // R2 R3 stores and readback
    send_cmd(8'h10, 3);
    send_cmd(8'h11, 2);
    send_cmd(8'h12, 2);
    send_cmd(8'h13, 3);
    send_cmd(8'h14, 0);
    send_cmd(8'h15, 3);
    read_expect(8'h10, 3, "R2 hi0 readback");
    read_expect(8'h11, 2, "R2 lo0 readback");
    read_expect(8'h12, 2, "R2 hi1 readback");
    read_expect(8'h13, 3, "R2 lo1 readback");
    read_expect(8'h15, 3, "R3 burst1 readback");

    // R11 unused codes ignored
    send_cmd(8'h30, 16'hFFFF);
    send_cmd(8'h16, 16'h00AA);
    send_cmd(8'h00, 16'h0003);
    send_cmd(8'h1E, 16'h0003);
    read_expect(8'h10, 3, "R11 hi0 untouched");
    read_expect(8'h14, 0, "R11 burst0 untouched");
    read_expect(8'h1F, 0, "R11 mask untouched");
    check(pwm_out == 2'b00, "R11 outputs stay low", int'(pwm_out), 0);
    // R12 unused read select
    read_expect(8'h03, 0, "R12 unused select reads 0");
    read_expect(8'h16, 0, "R12 nonexistent channel reads 0");

    // R5 R6 R9: channel 0 continuous, lengths changed in first high
    expect_seg(0, 1, 3 * D);
    expect_seg(0, 0, 2 * D);
    for (int k = 0; k < 2; k++) begin
      expect_seg(0, 1, 5 * D);
      expect_seg(0, 0, 4 * D);
    end
    send_cmd(8'h1F, 1);
    check(pwm_out[0] == 1'b0, "R5 output not yet high one edge after command",
          int'(pwm_out[0]), 0);
    @(negedge clk);
    check(pwm_out[0] == 1'b1, "R5 output high two edges after command",
          int'(pwm_out[0]), 1);
    send_cmd(8'h10, 5);
    send_cmd(8'h11, 4);
    read_expect(8'h1F, 1, "R4 mask readback");
    wait_q(0);
    check(q0.size() == 0, "R6 continuous periods all seen", q0.size(), 0);

    // R8 disable right after a rising edge
    while (pwm_out[0] != 1'b0) @(negedge clk);
    while (pwm_out[0] != 1'b1) @(negedge clk);
    send_cmd(8'h1F, 0);
    check(pwm_out[0] == 1'b1, "R8 output still high one edge after disable",
          int'(pwm_out[0]), 1);
    @(negedge clk);
    check(pwm_out[0] == 1'b0, "R8 output low two edges after disable",
          int'(pwm_out[0]), 0);
    begin
      bit stayed = 1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pwm_out[0]) stayed = 0;
      end
      check(stayed, "R8 output stays low while disabled", int'(!stayed), 0);
    end
    in_run[0] = 0;

    // R7 R10: ch1 burst of 3 while ch0 runs continuously
    send_cmd(8'h10, 1);
    send_cmd(8'h11, 1);
    for (int k = 0; k < 2; k++) begin
      expect_seg(0, 1, D);
      expect_seg(0, 0, D);
    end
    for (int k = 0; k < 3; k++) begin
      expect_seg(1, 1, 2 * D);
      if (k < 2) expect_seg(1, 0, 3 * D);
    end
    send_cmd(8'h1F, 3);
    wait_q(1);
    check(q1.size() == 0, "R7 burst periods all seen", q1.size(), 0);
    repeat (3 * D + 6) @(negedge clk);
    check(pwm_out[1] == 1'b0, "R7 burst channel low after end", int'(pwm_out[1]), 0);
    read_expect(8'h1F, 1, "R7 R10 mask bit1 cleared, bit0 kept");
    begin
      bit quiet = 1;
      bit other = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (pwm_out[1]) quiet = 0;
        if (pwm_out[0]) other = 1;
      end
      check(quiet, "R7 no pulse after burst end", int'(!quiet), 0);
      check(other, "R10 channel 0 keeps running", int'(other), 1);
    end
    check(q0.size() == 0, "R10 channel 0 periods all seen", q0.size(), 0);

    // R7 re-arm with burst of 1
    send_cmd(8'h1F, 0);
    repeat (3) @(negedge clk);
    in_run[0] = 0;
    in_run[1] = 0;
    send_cmd(8'h15, 1);
    expect_seg(1, 1, 2 * D);
    send_cmd(8'h1F, 2);
    wait_q(1);
    repeat (3 * D + 6) @(negedge clk);
    read_expect(8'h1F, 0, "R7 single-period burst clears mask");
    check(pwm_out == 2'b00, "R7 all outputs low at end", int'(pwm_out), 0);

    repeat (4) @(negedge clk);
    check(rdq.size() == 0, "R12 every read answered", rdq.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule